// File: doc/BRIEF.md
# Status and Error Flag Register Bank

This block gathers event pulses and live FIFO levels from a serial-peripheral datapath into a small set of readable registers. Events are captured into sticky bits. Software clears these bits by writing a one to each bit it wants cleared, which is normally the value it has just read back. An enable register sits beside each error group, and a mask register sits beside the operational service and done bits. Together they decide which captured bits drive a single active-high, level interrupt line.

A plain synchronous register port gives access to the registers. Reads are combinational from the address. Writes take effect at the clock edge while the write strobe is high. The FIFO full and not-empty indications are not stored. They are shown live in the operational register, and writes do not affect them. Bit positions are fixed because interrupt handlers decode them directly. Register addresses are word indices: 0 operational, 1 operational mask, 2 transfer error, 3 transfer error enable, 4 serial-clock error, 5 serial-clock error enable.

Top module: `spi_flag_bank`

## Requirements
- R1: After reset every sticky flag, every enable bit and every mask bit is 0, and `irq` is low.
- R2: Address 0 reads the sticky flags at bits 11..8 as `op_evt[3:0]` (11 input-count done, 10 output-count done, 9 input service, 8 output service) and `fifo_live[3:0]` at bits 7..4 (7 input FIFO full, 6 output FIFO full, 5 input FIFO not empty, 4 output FIFO not empty). Bits 7..4 follow the inputs in the same cycle and are not changed by writes. All other bits read 0.
- R3: A high `op_evt` bit sets its sticky flag at the next edge. The flag holds until a write to address 0 with a one in that bit position. Zeros in the written data leave flags unchanged.
- R4: Address 2 holds the transfer error flags from `xerr_evt[3:0]` at bits 5..2 (5 output overrun, 4 input underrun, 3 output underrun, 2 input overrun). They are sticky and write-one-to-clear, and the other bits read 0.
- R5: Address 4 holds the serial-clock error flags from `sck_evt[1:0]` at bits 1..0 (1 clock overrun, 0 clock underrun). They are sticky and write-one-to-clear, and the other bits read 0.
- R6: Address 3 stores transfer error enables at bits 5..2 and address 5 stores clock error enables at bits 1..0. Each is plainly written and read back, and bits outside these fields read 0.
- R7: Address 1 stores mask bits at 11..8, matching the sticky operational flags. A 1 in a mask bit keeps that flag from raising the interrupt.
- R8: When an event and a clearing write hit the same flag in the same cycle, the flag is set after the edge.
- R9: `irq` is registered. It is high in the cycle after any enabled error flag or any unmasked sticky operational flag is set, and it stays high until all such flags are cleared or disabled.
- R10: Addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Register word address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr` |
| op_evt | input | 4 | Service and done event pulses (bit 3 input done .. bit 0 output service) |
| fifo_live | input | 4 | Live FIFO levels (bit 3 input full .. bit 0 output not empty) |
| xerr_evt | input | 4 | Transfer error pulses (bit 3 output overrun .. bit 0 input overrun) |
| sck_evt | input | 2 | Serial-clock error pulses (bit 1 overrun, bit 0 underrun) |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench builds the block with a 32-bit data word, a 3-bit address and the registered interrupt stage (IRQ_REG = 1). The 3-bit address brings the two unmapped words within reach of random traffic. The registered stage makes the one-cycle interrupt latency observable. Random traffic mixes write-back clears with arbitrary data, so set-against-clear collisions and partial clears happen often. Directed steps cover full masking, the case where an event and a clear land on the same flag in the same cycle, and enable writes with bits set outside the field.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
   // Field placement inside the data word; handlers decode these positions.
   localparam int OP_STICKY_LSB = 8;
   localparam int OP_STICKY_N   = 4;
   localparam int OP_LIVE_LSB   = 4;
   localparam int OP_LIVE_N     = 4;
   localparam int XERR_LSB      = 2;
   localparam int XERR_N        = 4;
   localparam int SCK_LSB       = 0;
   localparam int SCK_N         = 2;
   localparam int OP_TOP_BIT    = OP_STICKY_LSB + OP_STICKY_N;

   // Register word addresses.
   localparam int RA_OP        = 0;
   localparam int RA_OP_MASK   = 1;
   localparam int RA_XERR      = 2;
   localparam int RA_XERR_EN   = 3;
   localparam int RA_SCK       = 4;
   localparam int RA_SCK_EN    = 5;
   localparam int RA_COUNT     = 6;
endpackage

// File: rtl/sfb_w1c_bank.sv
module sfb_w1c_bank #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] q_o
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_cell
      logic cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cell_q <= 1'b0;
         else if (set_i[b])   cell_q <= 1'b1;   // set beats clear
         else if (clr_i[b])   cell_q <= 1'b0;
      end
      assign q_o[b] = cell_q;
   end
endmodule

// File: rtl/sfb_cfg_reg.sv
module sfb_cfg_reg #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (we_i) q_o <= d_i;
   end
endmodule

// File: rtl/sfb_irq_merge.sv
module sfb_irq_merge #(
   parameter int N       = 10,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pend_i,
   output logic         irq_o
);
   logic any_pend;
   assign any_pend = |pend_i;

   if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_pend;
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_o = any_pend;
   end
endmodule

// File: rtl/spi_flag_bank.sv
module spi_flag_bank
   import sfb_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 3,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [3:0]        op_evt,
   input  logic [3:0]        fifo_live,
   input  logic [3:0]        xerr_evt,
   input  logic [1:0]        sck_evt,
   output logic              irq
);
   localparam int PEND_N = OP_STICKY_N + XERR_N + SCK_N;

   if (DATA_W < OP_TOP_BIT) begin : g_bad_data_w
      $error("spi_flag_bank: DATA_W too small for the operational fields");
   end
   if ((1 << ADDR_W) < RA_COUNT) begin : g_bad_addr_w
      $error("spi_flag_bank: ADDR_W cannot reach every register");
   end

   // Write decode
   logic hit_op, hit_mask, hit_xerr, hit_xerr_en, hit_sck, hit_sck_en;
   assign hit_op      = reg_wr && (reg_addr == ADDR_W'(RA_OP));
   assign hit_mask    = reg_wr && (reg_addr == ADDR_W'(RA_OP_MASK));
   assign hit_xerr    = reg_wr && (reg_addr == ADDR_W'(RA_XERR));
   assign hit_xerr_en = reg_wr && (reg_addr == ADDR_W'(RA_XERR_EN));
   assign hit_sck     = reg_wr && (reg_addr == ADDR_W'(RA_SCK));
   assign hit_sck_en  = reg_wr && (reg_addr == ADDR_W'(RA_SCK_EN));

   logic [OP_STICKY_N-1:0] op_clr, op_sticky_q, op_mask_q;
   logic [XERR_N-1:0]      xerr_clr, xerr_q, xerr_en_q;
   logic [SCK_N-1:0]       sck_clr, sck_q, sck_en_q;

   assign op_clr   = hit_op   ? reg_wdata[OP_STICKY_LSB +: OP_STICKY_N] : '0;
   assign xerr_clr = hit_xerr ? reg_wdata[XERR_LSB +: XERR_N]           : '0;
   assign sck_clr  = hit_sck  ? reg_wdata[SCK_LSB +: SCK_N]             : '0;

   sfb_w1c_bank #(.WIDTH(OP_STICKY_N)) u_op_flags (
      .clk(clk), .rst_n(rst_n), .set_i(op_evt), .clr_i(op_clr), .q_o(op_sticky_q));
   sfb_w1c_bank #(.WIDTH(XERR_N)) u_xerr_flags (
      .clk(clk), .rst_n(rst_n), .set_i(xerr_evt), .clr_i(xerr_clr), .q_o(xerr_q));
   sfb_w1c_bank #(.WIDTH(SCK_N)) u_sck_flags (
      .clk(clk), .rst_n(rst_n), .set_i(sck_evt), .clr_i(sck_clr), .q_o(sck_q));

   sfb_cfg_reg #(.WIDTH(OP_STICKY_N)) u_op_mask (
      .clk(clk), .rst_n(rst_n), .we_i(hit_mask),
      .d_i(reg_wdata[OP_STICKY_LSB +: OP_STICKY_N]), .q_o(op_mask_q));
   sfb_cfg_reg #(.WIDTH(XERR_N)) u_xerr_en (
      .clk(clk), .rst_n(rst_n), .we_i(hit_xerr_en),
      .d_i(reg_wdata[XERR_LSB +: XERR_N]), .q_o(xerr_en_q));
   sfb_cfg_reg #(.WIDTH(SCK_N)) u_sck_en (
      .clk(clk), .rst_n(rst_n), .we_i(hit_sck_en),
      .d_i(reg_wdata[SCK_LSB +: SCK_N]), .q_o(sck_en_q));

   // Interrupt sources
   logic [PEND_N-1:0] pend;
   assign pend = {op_sticky_q & ~op_mask_q, xerr_q & xerr_en_q, sck_q & sck_en_q};

   sfb_irq_merge #(.N(PEND_N), .IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .irq_o(irq));

   // Read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(RA_OP): begin
            reg_rdata[OP_STICKY_LSB +: OP_STICKY_N] = op_sticky_q;
            reg_rdata[OP_LIVE_LSB +: OP_LIVE_N]     = fifo_live;
         end
         ADDR_W'(RA_OP_MASK): reg_rdata[OP_STICKY_LSB +: OP_STICKY_N] = op_mask_q;
         ADDR_W'(RA_XERR):    reg_rdata[XERR_LSB +: XERR_N] = xerr_q;
         ADDR_W'(RA_XERR_EN): reg_rdata[XERR_LSB +: XERR_N] = xerr_en_q;
         ADDR_W'(RA_SCK):     reg_rdata[SCK_LSB +: SCK_N]   = sck_q;
         ADDR_W'(RA_SCK_EN):  reg_rdata[SCK_LSB +: SCK_N]   = sck_en_q;
         default:             reg_rdata = '0;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;
endmodule

// File: rtl/sfb_flag_checker.sv
module sfb_flag_checker
   import sfb_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [3:0]        op_clr,
   input logic [3:0]        op_evt,
   input logic [3:0]        xerr_evt,
   input logic [1:0]        sck_evt,
   input logic [3:0]        op_q,
   input logic [3:0]        xerr_q,
   input logic [1:0]        sck_q,
   input logic              irq
);
   logic op_write;
   assign op_write = reg_wr && (reg_addr == ADDR_W'(RA_OP));

   AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_evt == '0 && !op_write) |=> $stable(op_q)); // R3

   AST_OP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_write && op_evt == '0) |=> ((op_q & $past(op_clr)) == '0)); // R3

   AST_OP_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_evt != '0) |=> ((op_q & $past(op_evt)) == $past(op_evt))); // R8

   AST_XERR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (xerr_evt != '0) |=> ((xerr_q & $past(xerr_evt)) == $past(xerr_evt))); // R4

   AST_SCK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_evt != '0) |=> ((sck_q & $past(sck_evt)) == $past(sck_evt))); // R5

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == '0 && xerr_q == '0 && sck_q == '0 &&
       op_evt == '0 && xerr_evt == '0 && sck_evt == '0) |=> !irq); // R9
endmodule

bind spi_flag_bank sfb_flag_checker #(.ADDR_W(ADDR_W)) u_flag_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .op_clr(op_clr), .op_evt(op_evt), .xerr_evt(xerr_evt), .sck_evt(sck_evt),
   .op_q(op_sticky_q), .xerr_q(xerr_q), .sck_q(sck_q), .irq(irq));

// File: tb/spi_flag_bank_test.sv
module spi_flag_bank_test;
   localparam int DW = 32;
   localparam int AW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [3:0]    op_evt = '0, fifo_live = '0, xerr_evt = '0;
   logic [1:0]    sck_evt = '0;
   logic [DW-1:0] rdata;
   logic          irq;

   spi_flag_bank #(.DATA_W(DW), .ADDR_W(AW), .IRQ_REG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .op_evt(op_evt), .fifo_live(fifo_live),
      .xerr_evt(xerr_evt), .sck_evt(sck_evt), .irq(irq));

   int  n_vec = 0, n_bad = 0;
   bit  finished = 0;

   // Reference state built from the requirements
   logic [3:0] m_op = '0, m_mask = '0, m_xe = '0, m_xen = '0;
   logic [1:0] m_ce = '0, m_cen = '0;
   logic       m_irq = 1'b0;

   function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
      logic [DW-1:0] r = '0;
      case (a)
         3'd0: begin r[11:8] = m_op; r[7:4] = fifo_live; end
         3'd1: r[11:8] = m_mask;
         3'd2: r[5:2]  = m_xe;
         3'd3: r[5:2]  = m_xen;
         3'd4: r[1:0]  = m_ce;
         3'd5: r[1:0]  = m_cen;
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string tag_of(logic [AW-1:0] a);
      case (a)
         3'd0: return "R2";
         3'd1: return "R7";
         3'd2: return "R4";
         3'd3: return "R6";
         3'd4: return "R5";
         3'd5: return "R6";
         default: return "R10";
      endcase
   endfunction

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (addr %0d)", tag, act, exp, addr);
      end
   endtask

   // Inputs are already driven (at a falling edge); check, advance one edge.
   task automatic tick(string rtag, string itag);
      logic [3:0] op_c, xe_c; logic [1:0] ce_c;
      #1;
      check(rtag, rdata, exp_read(addr));
      check(itag, {31'b0, irq}, {31'b0, m_irq});
      op_c = (wr && addr == 3'd0) ? wdata[11:8] : 4'h0;
      xe_c = (wr && addr == 3'd2) ? wdata[5:2]  : 4'h0;
      ce_c = (wr && addr == 3'd4) ? wdata[1:0]  : 2'h0;
      @(posedge clk);
      if (rst_n) begin
         m_irq = |(m_op & ~m_mask) | |(m_xe & m_xen) | |(m_ce & m_cen);
         m_op  = (m_op & ~op_c) | op_evt;
         m_xe  = (m_xe & ~xe_c) | xerr_evt;
         m_ce  = (m_ce & ~ce_c) | sck_evt;
         if (wr && addr == 3'd1) m_mask = wdata[11:8];
         if (wr && addr == 3'd3) m_xen  = wdata[5:2];
         if (wr && addr == 3'd5) m_cen  = wdata[1:0];
      end
      @(negedge clk);
   endtask

   task automatic drive(logic w, logic [AW-1:0] a, logic [DW-1:0] d,
                        logic [3:0] oe, logic [3:0] xe, logic [1:0] ce);
      wr = w; addr = a; wdata = d; op_evt = oe; xerr_evt = xe; sck_evt = ce;
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      @(negedge clk);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values at every address, irq low
      for (int a = 0; a < 8; a++) begin
         drive(1'b0, AW'(a), '0, '0, '0, '0);
         tick("R1", "R1");
      end

      // R2: live FIFO bits follow input, ignore writes
      fifo_live = 4'b1010;
      drive(1'b1, 3'd0, 32'h0000_00F0, '0, '0, '0);
      tick("R2", "R9");
      fifo_live = 4'b0101;
      drive(1'b0, 3'd0, '0, '0, '0, '0);
      tick("R2", "R9");

      // R3: capture, hold, partial clear by write-back
      drive(1'b0, 3'd0, '0, 4'b0110, '0, '0);
      tick("R3", "R9");
      drive(1'b0, 3'd0, '0, '0, '0, '0);
      repeat (3) tick("R3", "R9");
      drive(1'b1, 3'd0, 32'h0000_0400, '0, '0, '0);
      tick("R3", "R9");
      drive(1'b0, 3'd0, '0, '0, '0, '0);
      tick("R3", "R9");

      // R8: same-cycle event and clear on the same flag
      drive(1'b1, 3'd0, 32'h0000_0F00, 4'b0001, '0, '0);
      tick("R8", "R9");
      drive(1'b0, 3'd0, '0, '0, '0, '0);
      tick("R8", "R9");

      // R7: full mask blocks irq from operational flags
      drive(1'b1, 3'd1, 32'hFFFF_FFFF, '0, '0, '0);
      tick("R7", "R7");
      drive(1'b1, 3'd0, 32'h0000_0F00, '0, '0, '0);
      tick("R7", "R7");
      drive(1'b0, 3'd1, '0, 4'b1111, '0, '0);
      repeat (3) tick("R7", "R7");

      // R6: enables store only their field
      drive(1'b1, 3'd3, 32'hFFFF_FFFF, '0, '0, '0);
      tick("R6", "R9");
      drive(1'b1, 3'd5, 32'hFFFF_FFFF, '0, '0, '0);
      tick("R6", "R6");
      drive(1'b0, 3'd3, '0, '0, 4'b1000, 2'b01);
      tick("R6", "R9");
      drive(1'b0, 3'd2, '0, '0, '0, '0);
      repeat (2) tick("R4", "R9");
      drive(1'b0, 3'd4, '0, '0, '0, '0);
      tick("R5", "R9");

      // R10: unmapped writes have no effect
      drive(1'b1, 3'd6, 32'hFFFF_FFFF, '0, '0, '0);
      tick("R10", "R9");
      drive(1'b1, 3'd7, 32'hFFFF_FFFF, '0, '0, '0);
      tick("R10", "R9");
      for (int a = 0; a < 8; a++) begin
         drive(1'b0, AW'(a), '0, '0, '0, '0);
         tick("R10", "R9");
      end

      // Random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [AW-1:0] ra;
         logic [DW-1:0] rd;
         ra = AW'($urandom % 8);
         rd = (($urandom % 2) == 0) ? exp_read(ra) : $urandom;
         fifo_live = 4'($urandom);
         drive(($urandom % 5) < 2, ra, rd,
               (($urandom % 6) == 0) ? 4'($urandom) : 4'h0,
               (($urandom % 8) == 0) ? 4'($urandom) : 4'h0,
               (($urandom % 8) == 0) ? 2'($urandom) : 2'h0);
         tick(tag_of(ra), "R9");
      end

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule